// File: doc/BRIEF.md
# Timed two-pin pattern sequencer

The block plays back a stream of 32-bit command words written into it by a host. Each word carries a two-bit pin pattern in its low bits and a 30-bit hold count in its upper bits. The sequencer takes a word, drives the two output pins from the low field and then waits for the hold count before it takes the next word. Every command has a fixed overhead of four cycles, so a word holds its pin pattern for its hold count plus four cycles. A repeating table of such words, written in again and again, produces sync-style waveforms whose edges are exact to the cycle.

Words enter through a valid/ready write port into an internal FIFO. The FIFO holds four words, or eight when the depth select input is high. This suits hosts that refill in bursts. If the FIFO is empty when the next word is needed, the sequencer stalls with the pins frozen. It raises a stall output for each waiting cycle and latches a sticky underrun flag once it has run at least one command.

Top module: `pattern_seq`

## Requirements
- R1: After reset `pin_out` is 2'b00, `stall` is 1, `underrun` is 0 and `cmd_ready` is 1.
- R2: When a word is applied, `pin_out[0]` takes word bit 0 and `pin_out[1]` takes word bit 1.
- R3: With words available, each word holds its pin pattern for D+4 cycles, where D is word bits [31:2]. The count is tested for zero before it is decremented, so D=0 gives 4 cycles.
- R4: When the FIFO was empty and the sequencer was waiting, `pin_out` changes on the second rising edge after the edge that accepts a word.
- R5: `stall` is 1 in every cycle in which the sequencer needs a word and the FIFO is empty, and 0 while words keep arriving in time. During a stall `pin_out` keeps its value.
- R6: `underrun` becomes 1 after a stall that follows at least one consumed word. Waiting after reset does not set it, and once set it stays 1 until reset.
- R7: `cmd_ready` drops once 4 words are stored (`depth_sel`=0) or 8 words are stored (`depth_sel`=1). A word offered while `cmd_ready` is 0 is dropped and never reaches the pins.
- R8: Words are applied in the order in which they were accepted.
- R9: `depth_sel` changes only while the FIFO is empty and the sequencer is waiting for a word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_data | input | 32 | Command word: bits [1:0] pin pattern, bits [31:2] hold count |
| cmd_valid | input | 1 | Host offers `cmd_data` |
| cmd_ready | output | 1 | FIFO has room; a word is accepted when valid and ready are both high |
| depth_sel | input | 1 | 0 selects 4-word capacity, 1 selects 8-word capacity |
| pin_out | output | 2 | Driven pin pattern |
| stall | output | 1 | Sequencer waiting on an empty FIFO this cycle |
| underrun | output | 1 | Sticky: a stall occurred after the first command |

## Verification
The hardest state to reach from the ports is a full FIFO while the sequencer is busy, because the sequencer drains a word every few cycles and would otherwise keep room free. The stimulus first writes a lead word with a long hold count and then writes back-to-back until `cmd_ready` falls. This checks the capacity for both depth settings. It then offers a word with a distinctive pin pattern while the FIFO is full and confirms that the pattern never appears once the queued words have drained. Random streams with short, varied hold counts and the worked example (pattern 01 with count 4 held 8 cycles) check the edge-to-edge timing.

// File: rtl/pattern_seq_pkg.sv
package pattern_seq_pkg;

    // Sequencer steps, one cycle each except the hold step.
    typedef enum logic [1:0] {
        ST_FETCH = 2'd0,
        ST_APPLY = 2'd1,
        ST_LOAD  = 2'd2,
        ST_HOLD  = 2'd3
    } seq_state_e;

endpackage

// File: rtl/pattern_seq_fifo.sv
module pattern_seq_fifo #(
    parameter int WIDTH      = 32,
    parameter int BASE_DEPTH = 4,
    parameter int MAX_DEPTH  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             depth_sel,
    input  logic [WIDTH-1:0] push_data,
    input  logic             push_valid,
    output logic             push_ready,
    input  logic             pop_req,
    output logic [WIDTH-1:0] pop_data,
    output logic             empty
);

    localparam int AW = (MAX_DEPTH > 1) ? $clog2(MAX_DEPTH) : 1;
    localparam int CW = $clog2(MAX_DEPTH + 1);
    localparam logic [CW-1:0] CAP_LO   = CW'(BASE_DEPTH);
    localparam logic [CW-1:0] CAP_HI   = CW'(MAX_DEPTH);
    localparam logic [AW-1:0] PTR_LAST = AW'(MAX_DEPTH - 1);

    typedef struct packed {
        logic [MAX_DEPTH-1:0][WIDTH-1:0] mem;
        logic [AW-1:0]                   wr_ptr;
        logic [AW-1:0]                   rd_ptr;
        logic [CW-1:0]                   count;
    } fifo_t;

    fifo_t         fifo_d, fifo_q;
    logic [CW-1:0] cap;
    logic          push, pop;

    always_comb begin
        cap        = depth_sel ? CAP_HI : CAP_LO;
        push_ready = (fifo_q.count < cap);
        empty      = (fifo_q.count == '0);
        push       = push_valid && push_ready;
        pop        = pop_req && !empty;
        pop_data   = fifo_q.mem[fifo_q.rd_ptr];

        fifo_d = fifo_q;
        if (push) begin
            fifo_d.mem[fifo_q.wr_ptr] = push_data;
            fifo_d.wr_ptr = (fifo_q.wr_ptr == PTR_LAST) ? '0 : fifo_q.wr_ptr + AW'(1);
        end
        if (pop) begin
            fifo_d.rd_ptr = (fifo_q.rd_ptr == PTR_LAST) ? '0 : fifo_q.rd_ptr + AW'(1);
        end
        case ({push, pop})
            2'b10:   fifo_d.count = fifo_q.count + CW'(1);
            2'b01:   fifo_d.count = fifo_q.count - CW'(1);
            default: fifo_d.count = fifo_q.count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fifo_q <= '0;
        else        fifo_q <= fifo_d;
    end

    // Occupancy never exceeds the selected capacity.
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_q.count <= cap);

    // A lone push raises occupancy by exactly one.
    assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> (fifo_q.count == $past(fifo_q.count) + CW'(1)));

endmodule

// File: rtl/pattern_seq_core.sv
module pattern_seq_core
    import pattern_seq_pkg::*;
#(
    parameter int CMD_W = 32,
    parameter int PIN_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CMD_W-1:0] cmd_word,
    input  logic             cmd_avail,
    output logic             pop,
    output logic [PIN_W-1:0] pins,
    output logic             stall,
    output logic             underrun,
    output logic             idle
);

    localparam int DLY_W = CMD_W - PIN_W;

    typedef struct packed {
        seq_state_e       st;
        logic [CMD_W-1:0] osr;
        logic [DLY_W-1:0] cnt;
        logic [PIN_W-1:0] pins;
        logic             started;
        logic             underrun;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        pop   = 1'b0;
        stall = 1'b0;
        case (seq_q.st)
            ST_FETCH: begin
                if (cmd_avail) begin
                    pop           = 1'b1;
                    seq_d.osr     = cmd_word;
                    seq_d.started = 1'b1;
                    seq_d.st      = ST_APPLY;
                end else begin
                    stall = 1'b1;
                    if (seq_q.started) seq_d.underrun = 1'b1;
                end
            end
            ST_APPLY: begin
                seq_d.pins = seq_q.osr[PIN_W-1:0];
                seq_d.st   = ST_LOAD;
            end
            ST_LOAD: begin
                seq_d.cnt = seq_q.osr[CMD_W-1:PIN_W];
                seq_d.st  = ST_HOLD;
            end
            ST_HOLD: begin
                // zero test comes before the decrement
                if (seq_q.cnt == '0) seq_d.st  = ST_FETCH;
                else                 seq_d.cnt = seq_q.cnt - DLY_W'(1);
            end
            default: seq_d.st = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.st       <= ST_FETCH;
            seq_q.osr      <= '0;
            seq_q.cnt      <= '0;
            seq_q.pins     <= '0;
            seq_q.started  <= 1'b0;
            seq_q.underrun <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign pins     = seq_q.pins;
    assign underrun = seq_q.underrun;
    assign idle     = (seq_q.st == ST_FETCH);

    // The pattern register follows the fetched word's low field.
    assert_apply_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_APPLY) |=> (seq_q.pins == $past(seq_q.osr[PIN_W-1:0])));

    // Hold counter steps down by one and stays in the hold step.
    assert_countdown_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_HOLD && seq_q.cnt != '0) |=>
            (seq_q.st == ST_HOLD && seq_q.cnt == $past(seq_q.cnt) - DLY_W'(1)));

    // Pins frozen across a stalled cycle.
    assert_hold_pins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(seq_q.pins));

    // Underrun flag never clears outside reset.
    assert_underrun_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.underrun |=> seq_q.underrun);

endmodule

// File: rtl/pattern_seq.sv
module pattern_seq #(
    parameter int CMD_W      = 32,
    parameter int PIN_W      = 2,
    parameter int BASE_DEPTH = 4,
    parameter int MAX_DEPTH  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CMD_W-1:0] cmd_data,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic             depth_sel,
    output logic [PIN_W-1:0] pin_out,
    output logic             stall,
    output logic             underrun
);

    logic [CMD_W-1:0] head_word;
    logic             fifo_empty;
    logic             seq_pop;
    logic             seq_idle;

    pattern_seq_fifo #(
        .WIDTH      (CMD_W),
        .BASE_DEPTH (BASE_DEPTH),
        .MAX_DEPTH  (MAX_DEPTH)
    ) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .depth_sel  (depth_sel),
        .push_data  (cmd_data),
        .push_valid (cmd_valid),
        .push_ready (cmd_ready),
        .pop_req    (seq_pop),
        .pop_data   (head_word),
        .empty      (fifo_empty)
    );

    pattern_seq_core #(
        .CMD_W (CMD_W),
        .PIN_W (PIN_W)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_word  (head_word),
        .cmd_avail (!fifo_empty),
        .pop       (seq_pop),
        .pins      (pin_out),
        .stall     (stall),
        .underrun  (underrun),
        .idle      (seq_idle)
    );

    // Capacity selection may move only when nothing is queued or running.
    assert_mode_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(depth_sel) |-> (fifo_empty && seq_idle));

endmodule

// File: tb/sim_pattern_seq.sv
module sim_pattern_seq;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] cmd_data;
    logic        cmd_valid;
    logic        depth_sel;
    logic        cmd_ready;
    logic [1:0]  pin_out;
    logic        stall;
    logic        underrun;

    always #5 clk = ~clk;

    pattern_seq u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_data  (cmd_data),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .depth_sel (depth_sel),
        .pin_out   (pin_out),
        .stall     (stall),
        .underrun  (underrun)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int          n_chk  = 0;
    int          n_fail = 0;
    bit          done   = 0;
    logic [31:0] wq [0:15];
    int          acc0;
    logic [1:0]  last_p;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(int dly, logic [1:0] p);
        return {dly[29:0], p};
    endfunction

    function automatic int dly_of(logic [31:0] w);
        return int'(w[31:2]);
    endfunction

    // Fill wq[start..start+n-1] with random holds and patterns that differ step to step.
    task automatic gen(int start, int n, logic [1:0] p0, int maxd);
        logic [1:0] p = p0;
        for (int i = start; i < start + n; i++) begin
            p = p ^ 2'(1 + ($urandom % 3));
            wq[i] = mk(int'($urandom % maxd), p);
        end
    endtask

    task automatic wait_change(output int t, output int stalls);
        stalls = 0;
        t = -1;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (stall) stalls++;
            if (pin_out !== last_p) begin
                t = cyc;
                last_p = pin_out;
                break;
            end
        end
    endtask

    task automatic observe(int n, bit first_lat);
        int t, tprev, st, stot;
        stot = 0;
        tprev = 0;
        for (int k = 0; k < n; k++) begin
            wait_change(t, st);
            chk(last_p == wq[k][1:0], "R2 R8", "applied pattern", last_p, wq[k][1:0]);
            if (k == 0) begin
                if (first_lat) chk(t - acc0 == 2, "R4", "latency from accept", t - acc0, 2);
            end else begin
                chk(t - tprev == dly_of(wq[k-1]) + 4, "R3", "hold cycles",
                    t - tprev, dly_of(wq[k-1]) + 4);
                stot += st;
            end
            tprev = t;
        end
        chk(stot == 0, "R5", "stall cycles while fed", stot, 0);
    endtask

    task automatic end_checks(logic [31:0] lastw);
        repeat (dly_of(lastw) + 6) @(negedge clk);
        chk(stall == 1'b1, "R5", "stall after drain", stall, 1);
        chk(pin_out == lastw[1:0], "R5", "pins held in stall", pin_out, lastw[1:0]);
        chk(underrun == 1'b1, "R6", "underrun after drain", underrun, 1);
    endtask

    task automatic writer(int n);
        for (int i = 0; i < n; i++) begin
            cmd_valid = 1'b1;
            cmd_data  = wq[i];
            while (!cmd_ready) @(negedge clk);
            @(posedge clk);
            @(negedge clk);
            if (i == 0) acc0 = cyc;
        end
        cmd_valid = 1'b0;
    endtask

    task automatic stream(int n);
        fork
            writer(n);
            observe(n, 1'b1);
        join
        end_checks(wq[n-1]);
    endtask

    task automatic fill_test(bit deep);
        int cap = deep ? 8 : 4;
        int acc = 0;
        depth_sel = deep;
        @(negedge clk);
        wq[0] = mk(60, last_p ^ 2'b01);
        gen(1, cap, wq[0][1:0], 3);
        fork
            begin
                cmd_valid = 1'b1;
                cmd_data  = wq[0];
                @(posedge clk);
                @(negedge clk);
                for (int i = 1; i <= cap; i++) begin
                    cmd_data = wq[i];
                    if (!cmd_ready) break;
                    @(posedge clk);
                    @(negedge clk);
                    acc++;
                end
                chk(acc == cap, "R7", "words accepted before full", acc, cap);
                chk(cmd_ready == 1'b0, "R7", "ready when full", cmd_ready, 0);
                cmd_data = mk(1, wq[cap][1:0] ^ 2'b11);
                repeat (3) @(negedge clk);
                cmd_valid = 1'b0;
            end
            observe(cap + 1, 1'b0);
        join
        end_checks(wq[cap]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R3 watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        depth_sel = 1'b0;
        cmd_valid = 1'b0;
        cmd_data  = '0;
        rst_n     = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pin_out == 2'b00, "R1", "pins after reset", pin_out, 0);
        chk(cmd_ready == 1'b1, "R1", "ready after reset", cmd_ready, 1);
        chk(underrun == 1'b0, "R1", "underrun after reset", underrun, 0);
        chk(stall == 1'b1, "R1", "stall after reset", stall, 1);
        repeat (10) @(negedge clk);
        chk(underrun == 1'b0, "R6", "no underrun before first word", underrun, 0);
        chk(stall == 1'b1, "R5", "stall while waiting", stall, 1);
        last_p = 2'b00;

        // worked example first (01 held 8 cycles), a zero hold included
        wq[0] = mk(4, 2'b01);
        wq[1] = mk(0, 2'b10);
        wq[2] = mk(3, 2'b11);
        wq[3] = mk(8, 2'b00);
        wq[4] = mk(5, 2'b01);
        stream(5);

        gen(0, 12, last_p, 13);
        stream(12);

        depth_sel = 1'b1;
        @(negedge clk);
        gen(0, 12, last_p, 13);
        stream(12);

        fill_test(1'b0);
        fill_test(1'b1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule